// File: doc/BRIEF.md
# Static Memory Byte-Lane Controller

This block sits between an on-chip request port and an external static memory port with six chip-select partitions. A request carries a partition index, a byte address, an access size, byte enables and right-justified write data. From these the block derives the chip select, the low external address bits, the active-low byte-lane masks and the data-lane placement. On reads it shifts the returned byte or halfword down to bit 0. Each partition has its own configured external width of 16 or 32 bits. A 32-bit access to a 16-bit partition is split into two halfword beats, and read data is assembled before the response.

Each partition also has a size-aware compatibility bit that changes how reads are presented. When the bit is clear, a read asserts every lane mask and zeroes the low address bits. When the bit is set, the read presents the true starting byte address and the request's byte enables, for targets that care about transfer size. Every external beat lasts a programmable number of clock cycles. A misaligned request gets an error response and starts no external cycle.

Top module: `smc_lane_ctrl`

## Requirements
- R1: An accepted request with partition index `req_cs` below 6 asserts only `mem_cs_n[req_cs]` (active low, bit i for partition i). The select is held unchanged for every cycle of the access and released after it.
- R2: On a partition with `cfg_wide` bit set (32-bit), a write drives `mem_addr` equal to the request address and `mem_mask_n` by size (0=8, 1=16, 2=32 bit) and offset. An 8-bit write at offset 0..3 gives 1110, 1101, 1011, 0111. A 16-bit write gives 1100 at offset 0 and 0011 at offset 2. A 32-bit write gives 0000.
- R3: On a 16-bit partition only `mem_mask_n[1:0]` is used and `mem_mask_n[3:2]` stays 11. An 8-bit write gives 10 when address bit 0 is 0 and 01 when it is 1. A 16-bit write gives 00.
- R4: A read on a partition whose `cfg_compat` bit is clear drives every used mask bit to 0. It forces the low address bits to zero: bits 1:0 on a 32-bit partition, bit 0 on a 16-bit one.
- R5: A read on a partition whose `cfg_compat` bit is set drives the low address bits from the lowest set bit of `req_be` (bit i = byte lane i). The mask is the complement of `req_be` on a 32-bit partition. On a 16-bit partition it is the complement of `req_be[3:2]` when address bit 1 is set, and of `req_be[1:0]` otherwise.
- R6: Read data for 8-bit and 16-bit reads is taken from the lane addressed by the request and returned on `rsp_rdata` bits 7:0 or 15:0, with upper bits zero. Only data bits 15:0 are used on a 16-bit partition.
- R7: Write data is replicated across lanes. An 8-bit write places `req_wdata[7:0]` in all four bytes, a 16-bit write places `req_wdata[15:0]` in both halves, and a 32-bit write on a 32-bit partition drives `req_wdata` unchanged.
- R8: A 32-bit access to a 16-bit partition takes two beats with mask 00. The first beat is at address offset 0 and carries the low halfword, the second is at offset 2 and carries the high halfword. A read returns `{second, first}` halfwords.
- R9: A request that is misaligned gets one response cycle with `rsp_err` = 1 and asserts no chip select. Misaligned means a 16-bit access at an odd address, a 32-bit access not at offset 0, size code 3, or a partition index of 6 or above.
- R10: `req_ready` is high only while idle. Each beat lasts `cfg_beat_len` cycles, with 0 treated as 1. `rsp_valid` pulses for one cycle in the cycle after the last beat.
- R11: During a beat exactly one strobe is low, `mem_we_n` for writes and `mem_oe_n` for reads. Both are high whenever no chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 6 | Per-partition width, 1 = 32-bit, 0 = 16-bit |
| cfg_compat | input | 6 | Per-partition size-aware read presentation enable |
| cfg_beat_len | input | 4 | Clock cycles per external beat (0 acts as 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Partition index |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| req_be | input | 4 | Byte enables for the word lanes |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Misaligned request |
| rsp_rdata | output | 32 | Aligned read data |
| mem_cs_n | output | 6 | Active-low chip selects |
| mem_addr | output | 24 | External byte address |
| mem_mask_n | output | 4 | Active-low byte-lane masks |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dout | output | 32 | Write data lanes |
| mem_din | input | 32 | Read data lanes |

## Verification
Writes run through every size and offset on a 32-bit partition and on a 16-bit partition. These sweeps separate the two mask tables and show whether the replicated write data lands on the addressed lane. The same reads are repeated with the compatibility bit clear and set. Masks and low address bits must change with the mode while the returned data must not, which separates presentation from data extraction. The memory model returns data that depends on address bit 1 on narrow partitions. A wrong beat order or a swapped halfword in a split word access therefore shows up in the read data. Misaligned requests, an invalid partition and two beat lengths check that errors start no cycle and that the select stays asserted for the programmed length.

// File: rtl/smc_lane_ctrl.sv
module smc_lane_ctrl #(
  parameter int ADDR_W = 24,
  parameter int NCS    = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCS-1:0]    cfg_wide,
  input  logic [NCS-1:0]    cfg_compat,
  input  logic [CNT_W-1:0]  cfg_beat_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [$clog2(NCS)-1:0] req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [NCS-1:0]    mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_mask_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [31:0]       mem_dout,
  input  logic [31:0]       mem_din
);
  localparam int CS_W = $clog2(NCS);
  localparam int NSEL = 1 << CS_W;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RSP} st_t;
  st_t st;

  logic [CS_W-1:0]   q_cs;
  logic              q_wr, q_wide, q_compat, q_two, q_beat, err_q;
  logic [1:0]        q_sz;
  logic [ADDR_W-1:0] q_addr;
  logic [3:0]        q_be;
  logic [31:0]       q_wd, rd_q;
  logic [CNT_W-1:0]  cnt;

  wire [NSEL-1:0] wide_ext   = NSEL'(cfg_wide);
  wire [NSEL-1:0] compat_ext = NSEL'(cfg_compat);
  wire cs_ok    = int'(req_cs) < NCS;
  wire misalign = (req_size == SZ_H && req_addr[0]) ||
                  (req_size == SZ_W && req_addr[1:0] != 2'b00) ||
                  (req_size == 2'd3);
  wire req_bad  = !cs_ok || misalign;
  wire [CNT_W-1:0] beat_len = (cfg_beat_len == '0) ? CNT_W'(1) : cfg_beat_len;
  wire busy     = (st == S_BUS);
  wire last_cyc = (cnt == CNT_W'(1));

  logic [31:0] ext, sized;
  always_comb begin
    if (q_wide) ext = mem_din >> {q_addr[1:0], 3'b000};
    else        ext = {16'h0000, mem_din[15:0]} >> {q_addr[0], 3'b000};
    case (q_sz)
      SZ_B:    sized = {24'h0, ext[7:0]};
      SZ_H:    sized = {16'h0, ext[15:0]};
      default: sized = ext;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      q_cs <= '0; q_wr <= 1'b0; q_wide <= 1'b0; q_compat <= 1'b0;
      q_two <= 1'b0; q_beat <= 1'b0; err_q <= 1'b0;
      q_sz <= SZ_B; q_addr <= '0; q_be <= '0; q_wd <= '0; rd_q <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          q_cs     <= req_cs;
          q_wr     <= req_write;
          q_sz     <= req_size;
          q_addr   <= req_addr;
          q_be     <= req_be;
          q_wd     <= req_wdata;
          q_wide   <= wide_ext[req_cs];
          q_compat <= compat_ext[req_cs];
          q_two    <= (req_size == SZ_W) && !wide_ext[req_cs];
          q_beat   <= 1'b0;
          cnt      <= beat_len;
          err_q    <= req_bad;
          st       <= req_bad ? S_RSP : S_BUS;
        end
        S_BUS: begin
          if (last_cyc) begin
            if (q_two) begin
              if (q_beat) rd_q[31:16] <= mem_din[15:0];
              else        rd_q[15:0]  <= mem_din[15:0];
            end else begin
              rd_q <= sized;
            end
            if (q_two && !q_beat) begin
              q_beat <= 1'b1;
              cnt    <= beat_len;
            end else begin
              st <= S_RSP;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0] lo_be;
  always_comb begin
    if      (q_be[0]) lo_be = 2'd0;
    else if (q_be[1]) lo_be = 2'd1;
    else if (q_be[2]) lo_be = 2'd2;
    else if (q_be[3]) lo_be = 2'd3;
    else              lo_be = 2'd0;
  end

  logic [3:0] lanes;
  always_comb begin
    case (q_sz)
      SZ_B:    lanes = 4'b0001 << q_addr[1:0];
      SZ_H:    lanes = 4'b0011 << q_addr[1:0];
      default: lanes = 4'b1111;
    endcase
  end
  wire [1:0] half_lanes = q_addr[1] ? lanes[3:2] : lanes[1:0];
  wire [1:0] half_be    = q_addr[1] ? q_be[3:2]  : q_be[1:0];

  logic [3:0] mask_w, mask_n16;
  logic [1:0] low_w, low_n16;
  always_comb begin
    if (q_wr)          begin mask_w = ~lanes; low_w = q_addr[1:0]; end
    else if (q_compat) begin mask_w = ~q_be;  low_w = lo_be;       end
    else               begin mask_w = 4'b0000; low_w = 2'b00;     end

    low_n16[1] = q_two ? q_beat : q_addr[1];
    if (q_two)         begin mask_n16 = 4'b1100;              low_n16[0] = 1'b0;      end
    else if (q_wr)     begin mask_n16 = {2'b11, ~half_lanes}; low_n16[0] = q_addr[0]; end
    else if (q_compat) begin mask_n16 = {2'b11, ~half_be};    low_n16[0] = lo_be[0];  end
    else               begin mask_n16 = 4'b1100;              low_n16[0] = 1'b0;      end
  end

  logic [31:0] wdata_lanes;
  always_comb begin
    case (q_sz)
      SZ_B:    wdata_lanes = {4{q_wd[7:0]}};
      SZ_H:    wdata_lanes = {2{q_wd[15:0]}};
      default: wdata_lanes = !q_two ? q_wd :
                             q_beat ? {2{q_wd[31:16]}} : {2{q_wd[15:0]}};
    endcase
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RSP);
  assign rsp_err    = err_q;
  assign rsp_rdata  = rd_q;
  assign mem_cs_n   = busy ? ~(NCS'(1) << q_cs) : '1;
  assign mem_we_n   = ~(busy & q_wr);
  assign mem_oe_n   = ~(busy & ~q_wr);
  assign mem_mask_n = !busy ? 4'b1111 : (q_wide ? mask_w : mask_n16);
  assign mem_addr   = {q_addr[ADDR_W-1:2], q_wide ? low_w : low_n16};
  assign mem_dout   = wdata_lanes;
endmodule

// File: rtl/smc_lane_ctrl_chk.sv
module smc_lane_ctrl_chk #(
  parameter int NCS = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cfg_wide,
  input logic [NCS-1:0] cfg_compat,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic [NCS-1:0] mem_cs_n,
  input logic [3:0]     mem_mask_n,
  input logic           mem_we_n,
  input logic           mem_oe_n
);
  wire idle_bus = &mem_cs_n;

  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  p_select_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_bus && $past(!idle_bus)) |-> $stable(mem_cs_n));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~mem_cs_n & ~cfg_wide)) |-> mem_mask_n[3:2] == 2'b11);

  p_plain_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && |(~mem_cs_n & ~cfg_compat)) |-> mem_mask_n[1:0] == 2'b00);

  p_err_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> $past(idle_bus));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (idle_bus && !rsp_valid));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_strobe_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle_bus == (mem_we_n && mem_oe_n));
endmodule

bind smc_lane_ctrl smc_lane_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_compat(cfg_compat),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .mem_cs_n(mem_cs_n), .mem_mask_n(mem_mask_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
);

// File: tb/smc_lane_ctrl_test.sv
`timescale 1ns/1ps
module smc_lane_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] cfg_wide = 6'b010101, cfg_compat = 6'b000000;
  logic [3:0] cfg_beat_len = 4'd0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_cs = '0;
  logic [23:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_we_n, mem_oe_n;
  logic [31:0] rsp_rdata, mem_dout, mem_din;
  logic [5:0] mem_cs_n;
  logic [23:0] mem_addr;
  logic [3:0] mem_mask_n;

  smc_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_compat(cfg_compat),
    .cfg_beat_len(cfg_beat_len), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
    .req_size(req_size), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_mask_n(mem_mask_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
    .mem_din(mem_din));

  function automatic logic [31:0] wword(input logic [5:0] x);
    return {x, 2'd3, x, 2'd2, x, 2'd1, x, 2'd0};
  endfunction
  function automatic logic [31:0] hword(input logic [6:0] y);
    return {16'hDEAD, y, 1'b1, y, 1'b0};
  endfunction
  wire wide_act = |(~mem_cs_n & cfg_wide);
  assign mem_din = wide_act ? wword(mem_addr[7:2]) : hword(mem_addr[7:1]);

  int n_chk = 0, n_err = 0, bl = 1;
  logic [33:0] expq[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [1:0] lowbe(input logic [3:0] be);
    for (int i = 0; i < 4; i++) if (be[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input bit wide, input logic [23:0] a, input logic [1:0] sz);
    logic [31:0] w, h0, h1;
    if (wide) begin
      w = wword(a[7:2]);
      if (sz == 0) return (w >> (8 * a[1:0])) & 32'hFF;
      if (sz == 1) return (w >> (16 * a[1])) & 32'hFFFF;
      return w;
    end
    if (sz == 2) begin
      h0 = hword({a[7:2], 1'b0}); h1 = hword({a[7:2], 1'b1});
      return {h1[15:0], h0[15:0]};
    end
    w = hword(a[7:1]);
    if (sz == 0) return (w >> (8 * a[0])) & 32'hFF;
    return w & 32'hFFFF;
  endfunction

  task automatic access(input bit wr, input logic [2:0] cs, input logic [23:0] a,
                        input logic [1:0] sz, input logic [3:0] be, input logic [31:0] wd,
                        input string tag);
    bit bad, wide, comp, two;
    int nb;
    logic [3:0] m; logic [1:0] lo; logic [31:0] d; logic [23:0] ea;
    bad = (cs > 5) || (sz == 3) || (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 0);
    wide = bad ? 1'b0 : cfg_wide[cs];
    comp = bad ? 1'b0 : cfg_compat[cs];
    two = (sz == 2) && !wide;
    nb = two ? 2 : 1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = cs; req_addr = a;
    req_size = sz; req_be = be; req_wdata = wd;
    expq.push_back({wr, bad, bad ? 32'h0 : exp_rd(wide, a, sz)});
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      check(&mem_cs_n, "R9 no select on error", 32'(mem_cs_n), 32'h3F);
      return;
    end
    for (int k = 0; k < nb * bl; k++) begin
      check(mem_cs_n == ~(6'b1 << cs), "R1 select", 32'(mem_cs_n), 32'(~(6'b1 << cs)));
      if (k % bl == 0) begin
        if (wide) begin
          d = (sz == 0) ? {4{wd[7:0]}} : (sz == 1) ? {2{wd[15:0]}} : wd;
          if (wr) begin
            lo = a[1:0];
            case ({sz, a[1:0]})
              4'b0000: m = 4'b1110; 4'b0001: m = 4'b1101;
              4'b0010: m = 4'b1011; 4'b0011: m = 4'b0111;
              4'b0100: m = 4'b1100; 4'b0110: m = 4'b0011;
              default: m = 4'b0000;
            endcase
          end else if (comp) begin m = ~be; lo = lowbe(be); end
          else begin m = 4'b0000; lo = 2'b00; end
        end else begin
          lo[1] = two ? 1'(k / bl) : a[1];
          d = (sz == 0) ? {4{wd[7:0]}} : (sz == 1) ? {2{wd[15:0]}} :
              (k / bl == 1) ? {2{wd[31:16]}} : {2{wd[15:0]}};
          if (two) begin m = 4'b1100; lo[0] = 1'b0; end
          else if (wr) begin m = {2'b11, (sz == 0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00}; lo[0] = a[0]; end
          else if (comp) begin m = {2'b11, ~(a[1] ? be[3:2] : be[1:0])}; lo[0] = lowbe(be) & 2'b01; end
          else begin m = 4'b1100; lo[0] = 1'b0; end
        end
        ea = {a[23:2], lo};
        check(mem_mask_n == m, {tag, " mask"}, 32'(mem_mask_n), 32'(m));
        check(mem_addr == ea, {tag, " address"}, 32'(mem_addr), 32'(ea));
        check(mem_we_n == !wr && mem_oe_n == wr, "R11 strobes",
              {30'b0, mem_we_n, mem_oe_n}, {30'b0, !wr, wr});
        if (wr) check(mem_dout == d, "R7 write lanes", mem_dout, d);
      end
      @(negedge clk);
    end
    check(&mem_cs_n && rsp_valid, "R10 beat length", {25'b0, rsp_valid, mem_cs_n}, {25'b0, 1'b1, 6'h3F});
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [33:0] e;
      if (expq.size() == 0) check(1'b0, "R10 unexpected response", 32'h1, 32'h0);
      else begin
        e = expq.pop_front();
        check(rsp_err == e[32], "R9 error flag", 32'(rsp_err), 32'(e[32]));
        if (!e[33] && !e[32]) check(rsp_rdata == e[31:0], "R6 read data", rsp_rdata, e[31:0]);
      end
    end
  end

  initial begin
    #800000;
    check(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(&mem_cs_n && req_ready && !rsp_valid && mem_we_n && mem_oe_n && mem_mask_n == 4'hF,
          "R10 reset state", {26'b0, mem_cs_n}, 32'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 and R7: 32-bit partition write table
    access(1, 0, 24'h40, 0, 4'b0001, 32'h000000A5, "R2");
    access(1, 0, 24'h41, 0, 4'b0010, 32'h0000003C, "R2");
    access(1, 0, 24'h42, 0, 4'b0100, 32'h00000077, "R2");
    access(1, 0, 24'h43, 0, 4'b1000, 32'h000000E1, "R2");
    access(1, 0, 24'h44, 1, 4'b0011, 32'h0000BEEF, "R2");
    access(1, 0, 24'h46, 1, 4'b1100, 32'h00001234, "R2");
    access(1, 2, 24'h48, 2, 4'b1111, 32'hCAFEF00D, "R2");
    // R3: 16-bit partition writes
    access(1, 1, 24'h50, 0, 4'b0001, 32'h0000005A, "R3");
    access(1, 1, 24'h51, 0, 4'b0010, 32'h000000C3, "R3");
    access(1, 1, 24'h52, 1, 4'b1100, 32'h00009876, "R3");
    // R8: word write split on narrow partition
    access(1, 3, 24'h60, 2, 4'b1111, 32'h11223344, "R8");
    // R4 and R6: plain reads
    access(0, 0, 24'h71, 0, 4'b0010, 32'h0, "R4");
    access(0, 0, 24'h73, 0, 4'b1000, 32'h0, "R4");
    access(0, 0, 24'h76, 1, 4'b1100, 32'h0, "R4");
    access(0, 4, 24'h78, 2, 4'b1111, 32'h0, "R4");
    access(0, 1, 24'h83, 0, 4'b1000, 32'h0, "R4");
    access(0, 1, 24'h86, 1, 4'b1100, 32'h0, "R4");
    access(0, 3, 24'h88, 2, 4'b1111, 32'h0, "R8");
    // R5: size-aware reads on partitions 1 and 2
    cfg_compat = 6'b000110;
    access(0, 2, 24'h93, 0, 4'b1000, 32'h0, "R5");
    access(0, 2, 24'h91, 0, 4'b0010, 32'h0, "R5");
    access(0, 2, 24'h96, 1, 4'b1100, 32'h0, "R5");
    access(0, 1, 24'h97, 0, 4'b1000, 32'h0, "R5");
    access(0, 1, 24'h94, 1, 4'b0011, 32'h0, "R5");
    access(0, 0, 24'h93, 0, 4'b1000, 32'h0, "R4");
    cfg_compat = 6'b001000;
    access(0, 3, 24'hA4, 2, 4'b1111, 32'h0, "R8");
    // R9: rejected requests
    access(0, 0, 24'hB1, 1, 4'b0011, 32'h0, "R9");
    access(1, 2, 24'hB2, 2, 4'b1111, 32'h0, "R9");
    access(0, 0, 24'hB0, 3, 4'b1111, 32'h0, "R9");
    access(1, 6, 24'hB0, 0, 4'b0001, 32'h0, "R9");
    // R10 and R1: longer beats, other partitions
    cfg_beat_len = 4'd3; bl = 3;
    access(1, 5, 24'hC1, 0, 4'b0010, 32'h0000009C, "R3");
    access(0, 5, 24'hC4, 2, 4'b1111, 32'h0, "R8");
    access(0, 4, 24'hC2, 1, 4'b1100, 32'h0, "R4");
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R10 all responses", 32'(expq.size()), 32'h0);
    summary();
  end
endmodule